// File: doc/BRIEF.md
# I2C Master Serial Clock and Data-Slot Timer

This block produces the serial clock of a two-wire bus master and marks the moment inside each low phase when the data line may be changed. The high and low phases are timed independently from two 8-bit configuration registers. A phase programmed with value N lasts 4·N + 2 system clock cycles. The whole clock period is therefore 4·(low + high) + 4 cycles. A third 8-bit register sets how far after each falling edge the data-change slot falls. The block pulses an edge marker whenever the clock changes level and a one-cycle slot strobe when the data line may move. A serial shifting engine outside the block consumes these two signals.

The block also holds the byte-wide data register. Writes to it land in a transmit buffer that is offered downstream on a valid/ready stream. `tx_valid` stays high and `tx_data` stays stable until `tx_ready` is seen. A new write overwrites a pending byte and keeps it valid. Reads of the data register return a separate receive buffer, filled from an upstream valid/ready stream. That stream never applies back-pressure: `rx_ready` is always high, and the newest accepted byte replaces the older one. To place the data change near the middle of the low phase, set the hold value to roughly twice the low-period value.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, address 0 (data/receive) reads 0x00, address 1 (hold) reads 0x01, address 2 (low period) reads 0x3F and address 3 (high period) reads 0x3F. Also after reset, `scl_out` is 1, `scl_edge`, `sda_slot`, `hold_err` and `tx_valid` are 0.
- R2: While enabled, every SCL high phase after the first one lasts exactly 4·H + 2 clock cycles, where H is the value at address 3.
- R3: While enabled, every SCL low phase lasts exactly 4·L + 2 clock cycles, where L is the value at address 2.
- R4: If the first low cycle of a phase is cycle t, `sda_slot` is high for exactly one cycle, at cycle t + D + 2, where D is the value at address 1. The slot never falls in a cycle where `scl_out` is high or `scl_edge` is high.
- R5: If D ≥ 4·L when a low phase begins, that phase has no slot and `hold_err` is set. `hold_err` stays set until address 1 is written.
- R6: `scl_edge` is high for one cycle exactly in the first cycle of each new SCL level produced while enabled.
- R7: The period values are sampled only when a phase starts. A write made mid-phase leaves the current phase unchanged and takes effect from the next phase of that kind.
- R8: When `run_en` is low, `scl_out` goes high on the next cycle and stays high. Neither `scl_edge` nor `sda_slot` pulses, and the slot timer is cleared. Raising `run_en` starts a high phase.
- R9: A write to address 0 puts the byte on `tx_data` with `tx_valid` high. `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high. A read of address 0 does not return the transmit byte.
- R10: `rx_ready` is always 1. A cycle with `rx_valid` high stores `rx_data`, and address 0 then reads it without changing the transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 data, 1 hold, 2 low, 3 high) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| run_en | input | 1 | Clock generation enable |
| tx_data | output | 8 | Transmit buffer byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Downstream accepts the transmit byte |
| rx_data | input | 8 | Received byte from the shifter |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Receive buffer accepts (always 1) |
| scl_out | output | 1 | Serial clock level |
| scl_edge | output | 1 | One-cycle marker of each SCL level change |
| sda_slot | output | 1 | One-cycle data-change strobe |
| hold_err | output | 1 | Sticky flag: slot suppressed because the hold exceeded the low phase |

## Verification
The bench measures every phase length and slot position against 4·N + 2 and D + 2 for several settings, down to a 2-cycle high phase. It includes a slot placed in the very last low cycle, where an off-by-one comparison would drop the slot or push it into the high phase. It also tests a zero low period and a hold just one past the limit; a design that got either wrong would strobe while SCL is high or fail to raise the sticky flag. A period write in the middle of a low phase must not shorten that phase, and a design that reloads on every write would show a wrong length. Disabling mid-phase must leave SCL high with no stray edge marker, and the receive and transmit buffers must never alias through address 0.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_HOLD = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_HIGH = 2'd3
  } cfg_addr_e;

  localparam logic [7:0] DATA_INIT   = 8'h00;
  localparam logic [7:0] HOLD_INIT   = 8'h01;
  localparam logic [7:0] PERIOD_INIT = 8'h3F;
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_timing_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         hold_wr,
  output logic [W-1:0] hold_q,
  output logic [W-1:0] low_q,
  output logic [W-1:0] high_q,
  output logic [W-1:0] tx_q,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic [W-1:0] rx_d,
  input  logic         rx_valid
);
  logic [W-1:0] rx_q;
  logic         data_wr;

  assign data_wr = wr && (addr == ADDR_DATA);
  assign hold_wr = wr && (addr == ADDR_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= W'(HOLD_INIT);
      low_q  <= W'(PERIOD_INIT);
      high_q <= W'(PERIOD_INIT);
    end else if (wr) begin
      case (addr)
        ADDR_HOLD: hold_q <= wdata;
        ADDR_LOW:  low_q  <= wdata;
        ADDR_HIGH: high_q <= wdata;
        default:   ;
      endcase
    end
  end

  // transmit side: a write marks the byte pending, the handshake retires it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= W'(DATA_INIT);
      tx_valid <= 1'b0;
    end else if (data_wr) begin
      tx_q     <= wdata;
      tx_valid <= 1'b1;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // receive side: never stalls, newest byte wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= W'(DATA_INIT);
    else if (rx_valid) rx_q <= rx_d;
  end

  always_comb begin
    case (addr)
      ADDR_HOLD: rdata = hold_q;
      ADDR_LOW:  rdata = low_q;
      ADDR_HIGH: rdata = high_q;
      default:   rdata = rx_q;
    endcase
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] low_val,
  input  logic [W-1:0] high_val,
  output logic         scl,
  output logic         edge_q,
  output logic         fall_now
);
  localparam int CW = W + 2;

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [CW-1:0] low_len, high_len;

  // a phase of value N spans cnt values 4N+1 down to 0: 4N+2 cycles
  assign low_len  = {low_val, 2'b00} + CW'(1);
  assign high_len = {high_val, 2'b00} + CW'(1);

  assign fall_now = en && run_q && (cnt_q == '0) && scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl    <= 1'b1;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      edge_q <= 1'b0;
    end else if (!en) begin
      scl    <= 1'b1;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      edge_q <= 1'b0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      cnt_q  <= high_len;
      edge_q <= 1'b0;
    end else if (cnt_q == '0) begin
      scl    <= !scl;
      cnt_q  <= scl ? low_len : high_len;
      edge_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - CW'(1);
      edge_q <= 1'b0;
    end
  end
endmodule

// File: rtl/scl_hold_timer.sv
module scl_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fall_now,
  input  logic [W-1:0] hold_val,
  input  logic [W-1:0] low_val,
  input  logic         err_clr,
  output logic         slot_q,
  output logic         err_q
);
  localparam int HW = W + 1;
  localparam int LW = W + 2;

  logic [HW-1:0] hcnt_q;
  logic          armed_q;
  logic          too_long;
  logic          err_set;

  // slot index D+2 must not pass the last low index 4L+1
  assign too_long = {2'b00, hold_val} >= {low_val, 2'b00};
  assign err_set  = en && fall_now && too_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      armed_q <= 1'b0;
      slot_q  <= 1'b0;
    end else if (!en) begin
      hcnt_q  <= '0;
      armed_q <= 1'b0;
      slot_q  <= 1'b0;
    end else if (fall_now) begin
      slot_q  <= 1'b0;
      armed_q <= !too_long;
      hcnt_q  <= too_long ? '0 : ({1'b0, hold_val} + HW'(1));
    end else if (armed_q && (hcnt_q == '0)) begin
      slot_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      slot_q  <= 1'b0;
      if (armed_q) hcnt_q <= hcnt_q - HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  logic unused_lw;
  assign unused_lw = (LW == 0);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_addr,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         run_en,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic [W-1:0] rx_data,
  input  logic         rx_valid,
  output logic         rx_ready,
  output logic         scl_out,
  output logic         scl_edge,
  output logic         sda_slot,
  output logic         hold_err
);
  logic [W-1:0] hold_v, low_v, high_v;
  logic         hold_wr;
  logic         fall_now;

  assign rx_ready = 1'b1;

  scl_cfg_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .hold_wr  (hold_wr),
    .hold_q   (hold_v),
    .low_q    (low_v),
    .high_q   (high_v),
    .tx_q     (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_d     (rx_data),
    .rx_valid (rx_valid)
  );

  scl_phase_ctr #(.W(W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run_en),
    .low_val  (low_v),
    .high_val (high_v),
    .scl      (scl_out),
    .edge_q   (scl_edge),
    .fall_now (fall_now)
  );

  scl_hold_timer #(.W(W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run_en),
    .fall_now (fall_now),
    .hold_val (hold_v),
    .low_val  (low_v),
    .err_clr  (hold_wr),
    .slot_q   (sda_slot),
    .err_q    (hold_err)
  );
endmodule

// File: rtl/scl_timing_checker.sv
module scl_timing_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_wr,
  input logic [1:0]   cfg_addr,
  input logic         run_en,
  input logic [W-1:0] tx_data,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic         scl_out,
  input logic         scl_edge,
  input logic         sda_slot,
  input logic         hold_err
);
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> scl_out);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !sda_slot);

  assert_edge_is_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_edge |-> (scl_out != $past(scl_out)));

  assert_change_has_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((scl_out != $past(scl_out)) && $past(run_en)) |-> scl_edge);

  assert_slot_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_slot |-> (!scl_out && !scl_edge));

  assert_slot_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_slot |=> !sda_slot);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_err && !(cfg_wr && cfg_addr == 2'd1)) |=> hold_err);

  assert_tx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(cfg_wr && cfg_addr == 2'd0)) |=> (tx_valid && $stable(tx_data)));
endmodule

bind scl_timing_gen scl_timing_checker #(.W(W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_addr (cfg_addr),
  .run_en   (run_en),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .scl_out  (scl_out),
  .scl_edge (scl_edge),
  .sda_slot (sda_slot),
  .hold_err (hold_err)
);

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       run_en = 1'b0;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic       scl_out, scl_edge, sda_slot, hold_err;

  always #5 clk = !clk;

  scl_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run_en(run_en),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .scl_out(scl_out), .scl_edge(scl_edge), .sda_slot(sda_slot),
    .hold_err(hold_err)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  // scoreboard: kind 0 = low length, 1 = slot index (255 none), 2 = high length
  int exp_kind[$];
  int exp_val[$];
  string exp_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic push_bits(input int h, input int l, input int d, input int nbits, input string tag);
    for (int i = 0; i < nbits; i++) begin
      exp_kind.push_back(0); exp_val.push_back(4*l + 2); exp_tag.push_back({tag, " low R3"});
      exp_kind.push_back(1); exp_val.push_back((d >= 4*l) ? 255 : d + 2); exp_tag.push_back({tag, " slot R4"});
      exp_kind.push_back(2); exp_val.push_back(4*h + 2); exp_tag.push_back({tag, " high R2"});
    end
  endtask

  task automatic run_cfg(input int h, input int l, input int d, input int nbits, input string tag);
    wr_reg(2'd3, 8'(h));
    wr_reg(2'd2, 8'(l));
    wr_reg(2'd1, 8'(d));
    push_bits(h, l, d, nbits, tag);
    mon_on = 1'b1;
    @(posedge clk); #1 run_en = 1'b1;
    while (exp_kind.size() != 0) @(posedge clk);
    #1 run_en = 1'b0;
    repeat (3) @(posedge clk);
    mon_on = 1'b0;
  endtask

  // monitor
  bit prev_scl = 1'b1;
  bit en_p = 1'b0;
  bit first_hi = 1'b1;
  int cnt = 0;
  int slot_idx = 255;
  int edge_bad = 0;
  int edge_seen = 0;
  int slot_bad = 0;

  task automatic emit(input int kind, input int val);
    int ek, ev;
    string et;
    if (!mon_on) return;
    if (exp_kind.size() == 0) begin
      check(1'b0, "unexpected phase item", val, -1);
      return;
    end
    ek = exp_kind.pop_front();
    ev = exp_val.pop_front();
    et = exp_tag.pop_front();
    check(ek == kind && ev == val, et, val, ev);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_scl = 1'b1; en_p = 1'b0; first_hi = 1'b1; cnt = 0; slot_idx = 255;
    end else begin
      if (scl_edge != (en_p && (scl_out != prev_scl))) edge_bad++;
      if (scl_edge) edge_seen++;
      if (sda_slot && scl_out) slot_bad++;
      if (!en_p) begin
        first_hi = 1'b1; cnt = 1; slot_idx = 255;
      end else if (scl_out != prev_scl) begin
        if (scl_out) begin
          emit(0, cnt);
          emit(1, slot_idx);
        end else begin
          if (!first_hi) emit(2, cnt);
          first_hi = 1'b0;
          slot_idx = 255;
        end
        cnt = 1;
      end else begin
        cnt++;
      end
      if (sda_slot) slot_idx = cnt - 1;
      prev_scl = scl_out;
      en_p = run_en;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(scl_out == 1'b1, "R1 scl after reset", scl_out, 1);
    check({scl_edge, sda_slot, hold_err, tx_valid} == 4'b0, "R1 strobes after reset",
          {scl_edge, sda_slot, hold_err, tx_valid}, 0);
    rd_reg(2'd0, rv); check(rv == 8'h00, "R1 data reset", rv, 8'h00);
    rd_reg(2'd1, rv); check(rv == 8'h01, "R1 hold reset", rv, 8'h01);
    rd_reg(2'd2, rv); check(rv == 8'h3F, "R1 low reset", rv, 8'h3F);
    rd_reg(2'd3, rv); check(rv == 8'h3F, "R1 high reset", rv, 8'h3F);

    // R9 transmit buffer
    wr_reg(2'd0, 8'hA5);
    @(negedge clk);
    check(tx_valid && tx_data == 8'hA5, "R9 tx loaded", tx_data, 8'hA5);
    rd_reg(2'd0, rv); check(rv == 8'h00, "R9 read returns rx not tx", rv, 8'h00);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tx_valid && tx_data == 8'hA5, "R9 tx held without ready", tx_valid, 1);
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    @(negedge clk);
    check(!tx_valid, "R9 tx retired by handshake", tx_valid, 0);

    // R10 receive buffer
    check(rx_ready == 1'b1, "R10 rx_ready", rx_ready, 1);
    @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h3C;
    @(posedge clk); #1 rx_valid = 1'b0; rx_data = 8'h00;
    rd_reg(2'd0, rv); check(rv == 8'h3C, "R10 rx read", rv, 8'h3C);
    check(tx_data == 8'hA5 && !tx_valid, "R10 tx untouched by rx", tx_data, 8'hA5);

    // R2 R3 R4: minimum high, slot in the last low cycle
    run_cfg(0, 1, 3, 3, "cfgA");
    // R2 R3 R4: mid values
    run_cfg(3, 5, 10, 2, "cfgB");
    // R4: slot near mid-low
    run_cfg(1, 8, 15, 2, "cfgC");
    check(!hold_err, "R5 no error for legal holds", hold_err, 0);

    // R7 mid-phase write of low period
    wr_reg(2'd3, 8'd2); wr_reg(2'd2, 8'd2); wr_reg(2'd1, 8'd3);
    exp_kind.push_back(0); exp_val.push_back(10); exp_tag.push_back("R7 current low kept");
    exp_kind.push_back(1); exp_val.push_back(5);  exp_tag.push_back("R7 slot");
    exp_kind.push_back(2); exp_val.push_back(10); exp_tag.push_back("R7 high");
    exp_kind.push_back(0); exp_val.push_back(26); exp_tag.push_back("R7 next low uses new value");
    exp_kind.push_back(1); exp_val.push_back(5);  exp_tag.push_back("R7 slot after write");
    exp_kind.push_back(2); exp_val.push_back(10); exp_tag.push_back("R7 high after write");
    mon_on = 1'b1;
    @(posedge clk); #1 run_en = 1'b1;
    @(negedge clk);
    while (scl_out) @(negedge clk);
    repeat (3) @(posedge clk);
    #1 cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'd6;
    @(posedge clk); #1 cfg_wr = 1'b0;
    while (exp_kind.size() != 0) @(posedge clk);
    #1 run_en = 1'b0;
    repeat (3) @(posedge clk);
    mon_on = 1'b0;

    // R5 suppression with zero low period
    run_cfg(0, 0, 0, 2, "supL0");
    @(negedge clk);
    check(hold_err, "R5 error raised at L=0", hold_err, 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(hold_err, "R5 error sticky", hold_err, 1);
    wr_reg(2'd1, 8'd1);
    @(negedge clk);
    check(!hold_err, "R5 error cleared by hold write", hold_err, 0);
    // R5 hold one past the limit
    run_cfg(0, 1, 4, 2, "supL1");
    @(negedge clk);
    check(hold_err, "R5 error raised at D=4L", hold_err, 1);

    // R8 disable mid-low
    begin
      int bad = 0;
      wr_reg(2'd3, 8'd1); wr_reg(2'd2, 8'd4); wr_reg(2'd1, 8'd2);
      @(posedge clk); #1 run_en = 1'b1;
      @(negedge clk);
      while (scl_out) @(negedge clk);
      repeat (2) @(posedge clk);
      #1 run_en = 1'b0;
      @(posedge clk);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (!scl_out || scl_edge || sda_slot) bad++;
      end
      check(bad == 0, "R8 idle high and quiet", bad, 0);
    end

    check(edge_bad == 0 && edge_seen > 0, "R6 edge marker matches level changes", edge_bad, 0);
    check(slot_bad == 0, "R4 slot never while scl high", slot_bad, 0);
    check(exp_kind.size() == 0, "R2 scoreboard drained", exp_kind.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule